// File: doc/BRIEF.md
# DMA Trigger Source Selector and Request Latch

This block sits between a set of peripheral event lines and a DMA transfer engine. Each of its channels owns a small configuration byte. That byte holds a source selector, a pending-request flag, a sticky overflow flag and a configuration bit that marks internal RAM as the source or destination of the transfer. Each channel watches the one event line its selector picks. When that event fires, the channel raises its request towards the engine. The request stays up until the engine returns a one-cycle acknowledge.

Receive-type event lines come with an error qualifier that is asserted in the same cycle as the event. A receive event that carries an error does not start a transfer; the peripheral's own error interrupt reports the fault. Which event lines count as receive-type is set by a parameter mask. All other lines trigger whenever they are selected, whatever the qualifier shows.

Software reads and writes a channel's whole byte in a single access. A write that changes the selector always clears the pending flag in that same write. This keeps a request latched from the old source from being served against the new one.

Top module: `dma_trig_frontend`

## Requirements
- R1: After reset, every channel's selector, pending, overflow and RAM fields are zero, so `dma_req`, `dma_ram` and `reg_rdata` are all zero.
- R2: An event pulse on the line a channel selects sets that channel's pending flag. `dma_req` rises in the cycle after the pulse. Pulses on lines the channel does not select change nothing.
- R3: An event on a line marked receive-type in `RX_SRC_MASK` (lines 0 to 3 by default) that arrives with its `evt_err` bit high does not set pending and does not set overflow.
- R4: An event on a line not marked receive-type triggers whatever the value of its `evt_err` bit.
- R5: An acknowledge clears pending in the following cycle. If a qualified trigger and an acknowledge arrive in the same cycle, pending is left set.
- R6: The overflow flag is set when a qualified trigger arrives while pending is already 1. It stays set until a register write puts 0 in it.
- R7: `reg_rdata` shows the channel chosen by `reg_ch`, laid out as follows. Bit 7 is pending, bit 6 is overflow, bit 3 is the RAM bit and bits 2:0 are the selector. Bits 5:4 read 0.
- R8: A write whose selector differs from the stored one clears pending, whatever is in write bit 7. A write with an unchanged selector stores write bit 7 as the pending flag.
- R9: A write to a channel takes priority over a trigger or acknowledge on that channel in the same cycle. The channel then holds exactly the written fields, with R8 applied.
- R10: The RAM bit is stored from write bit 3 and driven on `dma_ram` for that channel.
- R11: Channels are independent. Writes, acknowledges and triggers for one channel leave every other channel's fields unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_pulse | input | NUM_SRC | Single-cycle peripheral event pulses |
| evt_err | input | NUM_SRC | Error qualifier, valid together with `evt_pulse` |
| dma_ack | input | NUM_CH | One-cycle acknowledge from the DMA engine, one per channel |
| dma_req | output | NUM_CH | Pending request for each channel |
| dma_ram | output | NUM_CH | Stored internal-RAM configuration bit for each channel |
| reg_wr | input | 1 | Byte write strobe |
| reg_ch | input | CH_W | Channel index for the read and the write |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Read byte of the channel selected by `reg_ch` |

## Verification
The bench builds the block with its default parameters. These are four channels and eight event lines, of which lines 0 to 3 are receive-type. The whole 3-bit selector range therefore points at real lines, and both the blocked-receive path and the unconditional-transmit path can be reached from every channel. A behavioural model is compared on every clock against all request and RAM outputs and against the byte being read back. A long phase with pseudo-random collisions follows the directed cases, which cover trigger with acknowledge, trigger with write, and a selector change against a written pending bit.

// File: rtl/dtf_pkg.sv
package dtf_pkg;
  localparam int SEL_W   = 3;
  localparam int NSEL    = 1 << SEL_W;
  localparam int BIT_PND = 7;
  localparam int BIT_OVF = 6;
  localparam int BIT_RAM = 3;

  typedef struct packed {
    logic             pend;
    logic             ovf;
    logic             ram;
    logic [SEL_W-1:0] sel;
  } ch_state_t;

  function automatic logic [7:0] pack_byte(ch_state_t s);
    logic [7:0] b;
    b            = '0;
    b[BIT_PND]   = s.pend;
    b[BIT_OVF]   = s.ovf;
    b[BIT_RAM]   = s.ram;
    b[SEL_W-1:0] = s.sel;
    return b;
  endfunction
endpackage

// File: rtl/dtf_rst_sync.sv
module dtf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n_sync = sh_q[1];
endmodule

// File: rtl/dtf_qualify.sv
module dtf_qualify
  import dtf_pkg::*;
#(
  parameter int               NUM_SRC     = 8,
  parameter logic [NSEL-1:0]  RX_SRC_MASK = 8'h0F
) (
  input  logic [NUM_SRC-1:0] evt_pulse,
  input  logic [NUM_SRC-1:0] evt_err,
  output logic [NSEL-1:0]    evt_ok
);
  for (genvar i = 0; i < NSEL; i++) begin : g_src
    if (i < NUM_SRC) begin : g_live
      if (RX_SRC_MASK[i]) begin : g_rx
        assign evt_ok[i] = evt_pulse[i] & ~evt_err[i];
      end else begin : g_tx
        assign evt_ok[i] = evt_pulse[i];
      end
    end else begin : g_none
      assign evt_ok[i] = 1'b0;
    end
  end
endmodule

// File: rtl/dtf_channel.sv
module dtf_channel
  import dtf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSEL-1:0] evt_ok,
  input  logic            wr_en,
  input  logic [7:0]      wdata,
  input  logic            ack,
  output ch_state_t       state
);
  ch_state_t        st_q, st_d;
  logic             trig;
  logic             upd;
  logic [SEL_W-1:0] wsel;

  assign trig = evt_ok[st_q.sel];
  assign wsel = wdata[SEL_W-1:0];
  assign upd  = wr_en | trig | ack;

  always_comb begin
    st_d = st_q;
    if (wr_en) begin
      st_d.sel  = wsel;
      st_d.ram  = wdata[BIT_RAM];
      st_d.ovf  = wdata[BIT_OVF];
      st_d.pend = (wsel != st_q.sel) ? 1'b0 : wdata[BIT_PND];
    end else begin
      st_d.ovf  = st_q.ovf | (trig & st_q.pend);
      st_d.pend = trig | (st_q.pend & ~ack);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= '0;
    else if (upd) st_q <= st_d;
  end

  assign state = st_q;

  AST_TRIG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && trig) |=> st_q.pend); // R2
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ack && !trig) |=> !st_q.pend); // R5
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && trig && st_q.pend) |=> st_q.ovf); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && st_q.ovf) |=> st_q.ovf); // R6
  AST_SEL_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wsel != st_q.sel)) |=> !st_q.pend); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !trig && !ack) |=> $stable(st_q)); // R11
endmodule

// File: rtl/dma_trig_frontend.sv
module dma_trig_frontend
  import dtf_pkg::*;
#(
  parameter int              NUM_CH      = 4,
  parameter int              NUM_SRC     = 8,
  parameter logic [NSEL-1:0] RX_SRC_MASK = 8'h0F,
  localparam int             CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_pulse,
  input  logic [NUM_SRC-1:0] evt_err,
  input  logic [NUM_CH-1:0]  dma_ack,
  output logic [NUM_CH-1:0]  dma_req,
  output logic [NUM_CH-1:0]  dma_ram,
  input  logic               reg_wr,
  input  logic [CH_W-1:0]    reg_ch,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata
);
  logic            rst_n_i;
  logic [NSEL-1:0] evt_ok;
  ch_state_t       ch_st [NUM_CH];

  dtf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  dtf_qualify #(
    .NUM_SRC     (NUM_SRC),
    .RX_SRC_MASK (RX_SRC_MASK)
  ) u_qual (
    .evt_pulse (evt_pulse),
    .evt_err   (evt_err),
    .evt_ok    (evt_ok)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_hit;
    assign wr_hit = reg_wr && (reg_ch == CH_W'(c));

    dtf_channel u_ch (
      .clk   (clk),
      .rst_n (rst_n_i),
      .evt_ok(evt_ok),
      .wr_en (wr_hit),
      .wdata (reg_wdata),
      .ack   (dma_ack[c]),
      .state (ch_st[c])
    );

    assign dma_req[c] = ch_st[c].pend;
    assign dma_ram[c] = ch_st[c].ram;
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_ch == CH_W'(c)) reg_rdata = pack_byte(ch_st[c]);
    end
  end

  AST_RDATA_RSVD: assert property (@(posedge clk) disable iff (!rst_n_i)
    reg_rdata[5:4] == 2'b00); // R7
endmodule

// File: tb/dma_trig_frontend_tb.sv
`timescale 1ns/1ps
module dma_trig_frontend_tb;
  localparam int NCH = 4;
  localparam int NSRC = 8;
  localparam logic [7:0] RXM = 8'h0F;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] evt_pulse = '0;
  logic [NSRC-1:0] evt_err = '0;
  logic [NCH-1:0]  dma_ack = '0;
  logic [NCH-1:0]  dma_req, dma_ram;
  logic            reg_wr = 1'b0;
  logic [1:0]      reg_ch = '0;
  logic [7:0]      reg_wdata = '0;
  logic [7:0]      reg_rdata;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  dma_trig_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .evt_err(evt_err),
    .dma_ack(dma_ack), .dma_req(dma_req), .dma_ram(dma_ram),
    .reg_wr(reg_wr), .reg_ch(reg_ch), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // behavioural reference model
  int mSel [NCH];
  bit mPnd [NCH];
  bit mOvf [NCH];
  bit mRam [NCH];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        mSel[c] = 0; mPnd[c] = 0; mOvf[c] = 0; mRam[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        bit hit;
        hit = evt_pulse[mSel[c]] && !(evt_err[mSel[c]] && RXM[mSel[c]]);
        if (reg_wr && reg_ch == c) begin
          mPnd[c] = (int'(reg_wdata[2:0]) != mSel[c]) ? 1'b0 : reg_wdata[7];
          mSel[c] = reg_wdata[2:0];
          mOvf[c] = reg_wdata[6];
          mRam[c] = reg_wdata[3];
        end else begin
          if (hit && mPnd[c]) mOvf[c] = 1'b1;
          mPnd[c] = hit || (mPnd[c] && !dma_ack[c]);
        end
      end
    end
  end

  function automatic logic [7:0] model_byte(int c);
    return {mPnd[c], mOvf[c], 2'b00, mRam[c], mSel[c][2:0]};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [NCH-1:0] er, em;
      for (int c = 0; c < NCH; c++) begin
        er[c] = mPnd[c];
        em[c] = mRam[c];
      end
      check("R2 dma_req vs model", 8'(dma_req), 8'(er));
      check("R10 dma_ram vs model", 8'(dma_ram), 8'(em));
      check("R7 reg_rdata vs model", reg_rdata, model_byte(int'(reg_ch)));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    evt_pulse = '0; evt_err = '0; dma_ack = '0; reg_wr = 1'b0;
  endtask

  task automatic wr(int c, logic [7:0] d);
    reg_ch = c[1:0]; reg_wdata = d; reg_wr = 1'b1;
  endtask

  task automatic run_main();
    #1;
    check("R1 rdata in reset", reg_rdata, 8'h00);
    check("R1 req in reset", 8'(dma_req), 8'h00);
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    repeat (4) tick();
    check("R1 rdata after reset", reg_rdata, 8'h00);

    wr(0, 8'h0D); tick();                       // sel=5, ram=1
    check("R7 layout", reg_rdata, 8'h0D);
    check("R10 ram out", 8'(dma_ram), 8'h01);
    evt_pulse[5] = 1; evt_err[5] = 1; tick();
    check("R4 tx with err triggers", 8'(dma_req), 8'h01);
    evt_pulse[4] = 1; tick();
    check("R2 unselected line ignored", reg_rdata, 8'h8D);
    evt_pulse[5] = 1; tick();
    check("R6 overflow set", reg_rdata, 8'hCD);
    dma_ack[0] = 1; tick();
    check("R5 ack clears, R6 sticky", reg_rdata, 8'h4D);
    wr(0, 8'h8A); tick();                       // sel 5->2, pend bit 1
    check("R8 sel change clears pend", reg_rdata, 8'h0A);
    evt_pulse[2] = 1; evt_err[2] = 1; tick();
    check("R3 rx with err blocked", reg_rdata, 8'h0A);
    evt_pulse[2] = 1; dma_ack[0] = 1; tick();
    check("R5 trig+ack keeps pend", reg_rdata, 8'h8A);
    wr(0, 8'h02); tick();
    check("R8 same sel stores pend 0", reg_rdata, 8'h02);
    wr(0, 8'h82); tick();
    check("R8 same sel stores pend 1", reg_rdata, 8'h82);
    wr(0, 8'h02); evt_pulse[2] = 1; tick();
    check("R9 write beats trigger", reg_rdata, 8'h02);
    wr(1, 8'h02); tick();
    evt_pulse[2] = 1; tick();
    check("R11 both ch0 ch1 pending", 8'(dma_req), 8'h03);
    dma_ack[1] = 1; tick();
    check("R11 ack ch1 only", 8'(dma_req), 8'h01);
    reg_ch = 2'd3; #0;
    check("R11 ch3 untouched", reg_rdata, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      evt_pulse = 8'($urandom) & 8'($urandom);
      evt_err   = 8'($urandom);
      dma_ack   = 4'($urandom) & 4'($urandom);
      reg_ch    = 2'($urandom);
      if (($urandom % 8) == 0) begin
        reg_wr = 1'b1;
        reg_wdata = 8'($urandom);
      end
      tick();
    end
    repeat (2) tick();
  endtask

  initial begin
    fork
      run_main();
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule